// File: doc/BRIEF.md
# Burst Byte Receiver with Idle Framing and Activity Timing

This block receives bytes from a producer over a four-phase request/acknowledge handshake and queues them in a FIFO. It sends them out on a single serial line as standard asynchronous frames. When the producer stays quiet for a programmable number of clock cycles after a burst, the block queues a fixed four-byte delimiter behind the last byte of that burst. The host on the serial link can then split the stream into bursts.

A second mode times bursts on a raw activity line instead. Every level change on that line, taken through a two-flop synchronizer, restarts the idle timer. When the timer expires, the block reports two values: the number of clock cycles between the first and last change of the burst, and the number of bytes accepted during that burst. The report comes with a one-cycle done pulse. Trailing idle time is never part of the measured span.

The FIFO depth, the bit period in clocks, the counter widths and the delimiter pattern are parameters. The idle limit is a port, so it can be changed at run time.

Top module: `burst_byte_uart_framer`

## Requirements
- R1: After reset, tx is high (idle), in_ack is low, meas_done is low, and meas_cycles and meas_bytes are zero.
- R2: Accepted bytes leave on tx in acceptance order. Each byte is sent as one frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts BIT_CLKS clocks, and the line is high between frames.
- R3: When in_req is high, in_ack is low and there is room, the byte is captured and in_ack goes high one clock later. in_ack then stays high while in_req stays high, and it falls one clock after in_req goes low. Each request cycle captures exactly one byte.
- R4: In byte mode (mode_measure = 0), after idle_limit idle cycles that follow an accepted byte, a delimiter is queued. It is the four bytes of DELIM, most significant byte first, and it is transmitted after every byte of that burst.
- R5: At most one delimiter is queued per idle period. No delimiter is queued if no byte was accepted since the previous delimiter.
- R6: While the FIFO is full, in_ack stays low even though in_req is high. No byte is dropped, and the pending byte is accepted once space frees.
- R7: In measurement mode (mode_measure = 1), only level changes of raw_line restart the idle timer. meas_done is high for exactly one cycle. It rises at the (idle_limit+3)-th rising edge after the edge that first samples the last change.
- R8: At the done pulse, meas_cycles equals the number of clock cycles between the first and the last raw_line change of the burst. meas_bytes equals the number of bytes accepted from the first change on. Both values hold until the next report.
- R9: In measurement mode, a delimiter is still queued at the end of a burst during which bytes were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_measure | input | 1 | 0 = restart timer on byte arrival, 1 = restart on raw_line changes |
| idle_limit | input | IDLE_W | Idle cycles that end a burst |
| in_data | input | 8 | Byte from the producer, stable while in_req is high |
| in_req | input | 1 | Producer request |
| in_ack | output | 1 | Receiver acknowledge |
| raw_line | input | 1 | Asynchronous activity line watched in measurement mode |
| tx | output | 1 | Serial output, idle high |
| meas_cycles | output | SPAN_W | Active span of the last measured burst, in clocks |
| meas_bytes | output | BCNT_W | Bytes accepted in the last measured burst |
| meas_done | output | 1 | One-cycle pulse when a measurement is reported |

## Verification
The handshake results are due at fixed points. in_ack is checked one clock after a request is presented and one clock after it is removed, and a blocked request is checked to stay unacknowledged ten clocks later. The done pulse is due at a fixed cycle, so the bench drives the last raw_line change at a falling edge and counts falling edges from there. It expects the pulse at exactly idle_limit+4 and nowhere else in the window. Serial output depends on queue and frame timing, so a bench decoder samples each bit at its centre. The bench waits a bounded time for the expected number of bytes and then a quiet period, so that missing, extra and reordered bytes are all caught.

// File: rtl/burst_byte_uart_framer.sv
module burst_byte_uart_framer #(
  parameter int          FIFO_AW  = 11,
  parameter int          BIT_CLKS = 25,
  parameter int          IDLE_W   = 16,
  parameter int          SPAN_W   = 24,
  parameter int          BCNT_W   = 16,
  parameter logic [31:0] DELIM    = 32'hD15E_A50F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_measure,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [7:0]        in_data,
  input  logic              in_req,
  output logic              in_ack,
  input  logic              raw_line,
  output logic              tx,
  output logic [SPAN_W-1:0] meas_cycles,
  output logic [BCNT_W-1:0] meas_bytes,
  output logic              meas_done
);

  localparam int DEPTH = 1 << FIFO_AW;
  localparam int BW    = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [BW-1:0] BAUD_END = BW'(BIT_CLKS - 1);

  logic [8:0]         mem [DEPTH];
  logic [FIFO_AW:0]   wr_ptr, rd_ptr, used;
  logic               full, empty, accept, mark_pend, mark_wr, push, pop;
  logic [8:0]         head;

  assign used    = wr_ptr - rd_ptr;
  assign full    = used[FIFO_AW];
  assign empty   = (used == '0);
  assign accept  = in_req & ~in_ack & ~full & ~mark_pend;
  assign mark_wr = mark_pend & ~full;
  assign push    = accept | mark_wr;
  assign head    = mem[rd_ptr[FIFO_AW-1:0]];

  always_ff @(posedge clk)
    if (push) mem[wr_ptr[FIFO_AW-1:0]] <= mark_wr ? 9'h100 : {1'b0, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      in_ack <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (accept)       in_ack <= 1'b1;
      else if (!in_req) in_ack <= 1'b0;
    end
  end

  // burst timing
  logic [2:0]        raw_s;
  logic              raw_edge, restart, first, tmo, burst_on, armed;
  logic [IDLE_W-1:0] idle_cnt;
  logic [SPAN_W-1:0] run, span;
  logic [BCNT_W-1:0] bytes;

  assign raw_edge = raw_s[1] ^ raw_s[2];
  assign restart  = mode_measure ? raw_edge : accept;
  assign first    = restart & ~burst_on;
  assign tmo      = burst_on & ~restart & (idle_cnt == idle_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_s       <= '0;
      burst_on    <= 1'b0;
      idle_cnt    <= '0;
      armed       <= 1'b0;
      mark_pend   <= 1'b0;
      run         <= '0;
      span        <= '0;
      bytes       <= '0;
      meas_cycles <= '0;
      meas_bytes  <= '0;
      meas_done   <= 1'b0;
    end else begin
      raw_s <= {raw_s[1:0], raw_line};

      if (restart)  burst_on <= 1'b1;
      else if (tmo) burst_on <= 1'b0;

      if (restart)       idle_cnt <= '0;
      else if (burst_on) idle_cnt <= idle_cnt + 1'b1;

      if (tmo)         armed <= 1'b0;
      else if (accept) armed <= 1'b1;

      if (tmo && armed) mark_pend <= 1'b1;
      else if (mark_wr) mark_pend <= 1'b0;

      if (first) begin
        run   <= '0;
        span  <= '0;
        bytes <= {{(BCNT_W-1){1'b0}}, accept};
      end else if (burst_on) begin
        run <= run + 1'b1;
        if (restart) span  <= run + 1'b1;
        if (accept)  bytes <= bytes + 1'b1;
      end

      meas_done <= tmo & mode_measure;
      if (tmo && mode_measure) begin
        meas_cycles <= span;
        meas_bytes  <= bytes;
      end
    end
  end

  // serial transmitter
  logic          tx_busy;
  logic [9:0]    frame;
  logic [3:0]    bits_left;
  logic [BW-1:0] baud;
  logic [1:0]    delim_left;
  logic [7:0]    next_byte;
  logic          load;

  assign load = ~tx_busy & ((delim_left != 2'd0) | ~empty);
  assign pop  = load & (delim_left == 2'd0);
  assign tx   = ~tx_busy | frame[0];

  always_comb begin
    case (delim_left)
      2'd3:    next_byte = DELIM[23:16];
      2'd2:    next_byte = DELIM[15:8];
      2'd1:    next_byte = DELIM[7:0];
      default: next_byte = head[8] ? DELIM[31:24] : head[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      tx_busy    <= 1'b0;
      frame      <= '1;
      bits_left  <= '0;
      baud       <= '0;
      delim_left <= '0;
    end else if (load) begin
      frame     <= {1'b1, next_byte, 1'b0};
      tx_busy   <= 1'b1;
      bits_left <= 4'd10;
      baud      <= '0;
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        if (head[8]) delim_left <= 2'd3;
      end else begin
        delim_left <= delim_left - 1'b1;
      end
    end else if (tx_busy) begin
      if (baud == BAUD_END) begin
        baud      <= '0;
        frame     <= {1'b1, frame[9:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == 4'd1) tx_busy <= 1'b0;
      end else begin
        baud <= baud + 1'b1;
      end
    end
  end

endmodule

module bbf_checks #(
  parameter int AW = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_req,
  input logic        in_ack,
  input logic        tx,
  input logic        meas_done,
  input logic [AW:0] used
);
  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CAP);
  a_r6_ack_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> ($past(used) < CAP));
  a_r3_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_req) |=> in_ack);
  a_r3_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !in_req) |=> !in_ack);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);
  a_r2_start_bit_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx) |=> !tx);
endmodule

bind burst_byte_uart_framer bbf_checks #(.AW(FIFO_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
  .tx(tx), .meas_done(meas_done), .used(used)
);

// File: tb/tb_burst_byte_uart_framer.sv
`timescale 1ns/1ps
module tb_burst_byte_uart_framer;
  localparam int BIT = 8;
  localparam int L   = 40;

  logic        clk = 1'b0, rst_n = 1'b0, mode_measure = 1'b0;
  logic [15:0] idle_limit = 16'(L);
  logic [7:0]  in_data = '0;
  logic        in_req = 1'b0, raw_line = 1'b0;
  logic        in_ack, tx, meas_done;
  logic [23:0] meas_cycles;
  logic [15:0] meas_bytes;

  int n_chk = 0, n_fail = 0, rx_n = 0, frame_err = 0, cyc = 0;
  logic [7:0] rx_b [256];

  burst_byte_uart_framer #(.FIFO_AW(3), .BIT_CLKS(BIT)) dut (
    .clk(clk), .rst_n(rst_n), .mode_measure(mode_measure), .idle_limit(idle_limit),
    .in_data(in_data), .in_req(in_req), .in_ack(in_ack), .raw_line(raw_line),
    .tx(tx), .meas_cycles(meas_cycles), .meas_bytes(meas_bytes), .meas_done(meas_done));

  initial forever #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // serial decoder, samples at bit centres
  initial forever begin
    @(negedge clk);
    if (rst_n && tx == 1'b0) begin
      logic [7:0] b;
      repeat (BIT/2) @(negedge clk);
      if (tx !== 1'b0) frame_err++;
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        b[i] = tx;
      end
      repeat (BIT) @(negedge clk);
      if (tx !== 1'b1) frame_err++;
      rx_b[rx_n[7:0]] = b;
      rx_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_all();
  end

  task automatic send_byte(input logic [7:0] b);
    int k = 0;
    @(negedge clk);
    in_data = b;
    in_req = 1'b1;
    while (!in_ack && k < 2000) begin @(negedge clk); k++; end
    chk("R3 ack seen", {31'd0, in_ack}, 32'd1);
    in_req = 1'b0;
    k = 0;
    while (in_ack && k < 10) begin @(negedge clk); k++; end
  endtask

  task automatic wait_rx(input int n, input string tag);
    int k = 0;
    while (rx_n < n && k < 20000) begin @(negedge clk); k++; end
    repeat (400) @(negedge clk);
    chk(tag, 32'(rx_n), 32'(n));
  endtask

  task automatic toggle(output int t);
    @(negedge clk);
    raw_line = ~raw_line;
    t = cyc;
  endtask

  task automatic t_reset();
    chk("R1 tx idle", {31'd0, tx}, 32'd1);
    chk("R1 ack low", {31'd0, in_ack}, 32'd0);
    chk("R1 done low", {31'd0, meas_done}, 32'd0);
    chk("R1 meas zero", {8'd0, meas_cycles} | {16'd0, meas_bytes}, 32'd0);
  endtask

  task automatic t_burst();
    logic [7:0] e [7] = '{8'h11, 8'h80, 8'h3C, 8'hD1, 8'h5E, 8'hA5, 8'h0F};
    int base = rx_n;
    @(negedge clk);
    in_data = 8'h11;
    in_req = 1'b1;
    @(negedge clk);
    chk("R3 ack after one clock", {31'd0, in_ack}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R3 ack held", {31'd0, in_ack}, 32'd1);
    in_req = 1'b0;
    @(negedge clk);
    chk("R3 ack released", {31'd0, in_ack}, 32'd0);
    send_byte(8'h80);
    send_byte(8'h3C);
    wait_rx(base + 7, "R4 burst plus delimiter count");
    for (int i = 0; i < 7; i++) chk("R2 R4 byte order", {24'd0, rx_b[base+i]}, {24'd0, e[i]});
  endtask

  task automatic t_no_repeat();
    int base = rx_n;
    repeat (800) @(negedge clk);
    chk("R5 single delimiter per idle", 32'(rx_n), 32'(base));
  endtask

  task automatic t_backpressure();
    int base = rx_n;
    int k = 0;
    idle_limit = 16'd1000;
    for (int i = 0; i < 9; i++) send_byte(8'(8'h40 + i));
    @(negedge clk);
    in_data = 8'h49;
    in_req = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 ack held low when full", {31'd0, in_ack}, 32'd0);
    while (!in_ack && k < 2000) begin @(negedge clk); k++; end
    chk("R6 accepted after space", {31'd0, in_ack}, 32'd1);
    in_req = 1'b0;
    @(negedge clk);
    send_byte(8'h4A);
    send_byte(8'h4B);
    wait_rx(base + 16, "R6 no loss count");
    for (int i = 0; i < 12; i++) chk("R6 R2 order", {24'd0, rx_b[base+i]}, 32'(8'h40 + i));
    chk("R4 delimiter after full burst", {24'd0, rx_b[base+12]}, 32'hD1);
    idle_limit = 16'(L);
  endtask

  task automatic t_measure();
    int t0, t1, tx_;
    int first_k = 0, nd = 0;
    int base = rx_n;
    mode_measure = 1'b1;
    toggle(t0);
    repeat (5) @(negedge clk);
    send_byte(8'hA1);
    send_byte(8'hB2);
    repeat (7) @(negedge clk);
    toggle(tx_);
    repeat (12) @(negedge clk);
    toggle(t1);
    for (int k = 1; k <= L + 7; k++) begin
      @(negedge clk);
      if (meas_done) begin nd++; if (first_k == 0) first_k = k; end
    end
    chk("R7 done cycle", 32'(first_k), 32'(L + 4));
    chk("R7 done width", 32'(nd), 32'd1);
    chk("R8 span", {8'd0, meas_cycles}, 32'(t1 - t0));
    chk("R8 bytes", {16'd0, meas_bytes}, 32'd2);
    wait_rx(base + 6, "R9 delimiter in measure mode");
    chk("R9 delimiter first byte", {24'd0, rx_b[base+2]}, 32'hD1);
  endtask

  task automatic t_measure_idle();
    int t0, t1, tm, k = 0;
    int base = rx_n;
    repeat (200) @(negedge clk);
    toggle(t0);
    repeat (2) @(negedge clk);
    toggle(tm);
    repeat (5) @(negedge clk);
    toggle(t1);
    while (!meas_done && k < 500) begin @(negedge clk); k++; end
    chk("R7 done seen", {31'd0, meas_done}, 32'd1);
    chk("R8 idle excluded span", {8'd0, meas_cycles}, 32'(t1 - t0));
    chk("R8 no bytes", {16'd0, meas_bytes}, 32'd0);
    repeat (300) @(negedge clk);
    chk("R8 value held", {8'd0, meas_cycles}, 32'(t1 - t0));
    chk("R5 no delimiter without bytes", 32'(rx_n), 32'(base));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_burst();
    t_no_repeat();
    t_backpressure();
    t_measure();
    t_measure_idle();
    chk("R2 framing errors", 32'(frame_err), 32'd0);
    finish_all();
  end
endmodule